// File: doc/BRIEF.md
# Timer Event Status Word

This block holds the event status word of a four-channel general-purpose timer. The timer core delivers one-cycle strobes: counter update, and per channel a capture strobe and a compare strobe. The block latches each strobe into a sticky flag. It also flags a second capture that arrives before software has acknowledged the first. The block watches the slave-mode trigger input itself. It synchronizes that input, finds its edges, and applies an edge rule that depends on the slave mode.

Software reads the status word at any time. It acknowledges flags by writing a full word in which the bits to be cleared are zero. An interrupt request is raised while any flag is set whose enable bit is also set. The bus port is a plain single-cycle write strobe with a read value that is always present. There is no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `tfr_status_top`

## Requirements
- R1: After reset the status word reads 0x0000_0000 and the interrupt request is low.
- R2: Status bit positions: bit 0 is the update flag, bits 1..4 are the capture/compare flags of channels 0..3, bit 6 is the trigger flag, and bits 9..12 are the over-capture flags of channels 0..3. All other bits always read zero.
- R3: An update strobe sets bit 0 at the next clock edge.
- R4: When a channel's input-mode bit is 1, its capture strobe sets its capture/compare flag and its compare strobe has no effect. When the bit is 0, the compare strobe sets the flag and the capture strobe has no effect.
- R5: A capture strobe on an input-mode channel sets that channel's over-capture flag when the channel's capture/compare flag was already set before that clock edge. This holds even if software clears the flag in the same cycle. Output-mode channels never set an over-capture flag.
- R6: A full-word write clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R7: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends set.
- R8: The trigger input passes through a 2-stage synchronizer and then an edge detector. With slave mode 0 (off), the trigger flag is never set. With any slave mode other than 0 and 5, only the active edge sets the trigger flag: the rising edge when the polarity input is 0, the falling edge when it is 1. The flag appears 3 clock edges after the input changes.
- R9: With slave mode 5 (pause), both edges of the trigger input set the trigger flag, whatever the polarity input.
- R10: A write whose byte strobe is not 4'b1111 changes no flag.
- R11: The interrupt request is high exactly when some status bit and the same bit of the enable vector are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_evt_i | input | 1 | Counter update strobe |
| cap_evt_i | input | 4 | Per-channel capture strobes |
| cmp_evt_i | input | 4 | Per-channel compare strobes |
| chan_in_i | input | 4 | Per-channel input-mode select (1 = input) |
| trig_i | input | 1 | Asynchronous trigger input |
| trig_pol_i | input | 1 | Active trigger edge: 0 rising, 1 falling |
| slv_mode_i | input | 3 | Slave mode: 0 off, 5 pause, others enabled |
| wr_en_i | input | 1 | Bus write strobe |
| wr_strb_i | input | 4 | Byte strobes of the write |
| wr_data_i | input | 32 | Write data (0 bits clear flags) |
| irq_en_i | input | 32 | Interrupt enable per status bit |
| rd_data_o | output | 32 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision of a software clear with a capture on a channel whose flag is already set. The bench has to place the acknowledge write in exactly the cycle of the second capture strobe. It must then see both the capture/compare flag and the over-capture flag set. The trigger edge rule is swept over several slave modes, both polarities and both edge directions. Before each edge the bench waits out the synchronizer latency and clears the word, so every flag it observes was caused by the single edge under test.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int unsigned NCH      = 4;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STRB_W   = WORD_W / 8;
  localparam int unsigned UPD_POS  = 0;
  localparam int unsigned CC_BASE  = 1;
  localparam int unsigned TRG_POS  = 6;
  localparam int unsigned OC_BASE  = 9;

  typedef enum logic [2:0] {
    SLV_OFF   = 3'd0,
    SLV_PAUSE = 3'd5
  } slv_code_e;

  function automatic logic [WORD_W-1:0] used_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[UPD_POS] = 1'b1;
    m[TRG_POS] = 1'b1;
    for (int i = 0; i < int'(NCH); i++) begin
      m[CC_BASE + i] = 1'b1;
      m[OC_BASE + i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tfr_trig_edge.sv
module tfr_trig_edge
  import tfr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic       trig_pol_i,
  input  logic [2:0] slv_mode_i,
  output logic       trig_evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;
  logic                   rise;
  logic                   fall;
  logic                   is_off;
  logic                   is_pause;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= trig_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], trig_i};
      end
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign rise     = lvl & ~prev_q;
  assign fall     = ~lvl & prev_q;
  assign is_off   = (slv_mode_i == SLV_OFF);
  assign is_pause = (slv_mode_i == SLV_PAUSE);

  always_comb begin
    if (is_off)        trig_evt_o = 1'b0;
    else if (is_pause) trig_evt_o = rise | fall;
    else               trig_evt_o = trig_pol_i ? fall : rise;
  end

  // R9
  pause_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_mode_i == 3'd5 && (lvl != prev_q)) |-> trig_evt_o);

  // R8
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_mode_i == 3'd0) |-> !trig_evt_o);
endmodule

// File: rtl/tfr_chan_slice.sv
module tfr_chan_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_evt_i,
  input  logic cmp_evt_i,
  input  logic is_input_i,
  input  logic cc_clr_i,
  input  logic oc_clr_i,
  output logic cc_flag_o,
  output logic oc_flag_o
);
  logic cc_q;
  logic oc_q;
  logic cc_set;
  logic oc_set;

  assign cc_set = is_input_i ? cap_evt_i : cmp_evt_i;
  assign oc_set = is_input_i & cap_evt_i & cc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q <= 1'b0;
      oc_q <= 1'b0;
    end else begin
      cc_q <= (cc_q & ~cc_clr_i) | cc_set;
      oc_q <= (oc_q & ~oc_clr_i) | oc_set;
    end
  end

  assign cc_flag_o = cc_q;
  assign oc_flag_o = oc_q;

  // R4
  cap_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_input_i && cap_evt_i) |=> cc_flag_o);

  // R5
  overcap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_input_i && cap_evt_i && cc_flag_o) |=> oc_flag_o);

  // R5
  out_no_oc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_input_i && !oc_flag_o) |=> !oc_flag_o);

  // R6
  cc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_clr_i && !cap_evt_i && !cmp_evt_i) |=> !cc_flag_o);
endmodule

// File: rtl/tfr_status_top.sv
module tfr_status_top
  import tfr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_evt_i,
  input  logic [NCH-1:0]    cap_evt_i,
  input  logic [NCH-1:0]    cmp_evt_i,
  input  logic [NCH-1:0]    chan_in_i,
  input  logic              trig_i,
  input  logic              trig_pol_i,
  input  logic [2:0]        slv_mode_i,
  input  logic              wr_en_i,
  input  logic [STRB_W-1:0] wr_strb_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [WORD_W-1:0] irq_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam logic [WORD_W-1:0] USED = used_mask();

  logic              wr_ok;
  logic [WORD_W-1:0] clr_vec;
  logic              upd_q;
  logic              trg_q;
  logic              trig_evt;
  logic [NCH-1:0]    cc_flags;
  logic [NCH-1:0]    oc_flags;
  logic [WORD_W-1:0] word;
  logic              unused_wr_bits;

  assign wr_ok   = wr_en_i & (&wr_strb_i);
  assign clr_vec = wr_ok ? (~wr_data_i & USED) : '0;
  assign unused_wr_bits = ^(wr_data_i & ~USED);

  tfr_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .trig_pol_i (trig_pol_i),
    .slv_mode_i (slv_mode_i),
    .trig_evt_o (trig_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      trg_q <= 1'b0;
    end else begin
      upd_q <= (upd_q & ~clr_vec[UPD_POS]) | upd_evt_i;
      trg_q <= (trg_q & ~clr_vec[TRG_POS]) | trig_evt;
    end
  end

  for (genvar c = 0; c < int'(NCH); c++) begin : g_ch
    tfr_chan_slice u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_evt_i  (cap_evt_i[c]),
      .cmp_evt_i  (cmp_evt_i[c]),
      .is_input_i (chan_in_i[c]),
      .cc_clr_i   (clr_vec[CC_BASE + c]),
      .oc_clr_i   (clr_vec[OC_BASE + c]),
      .cc_flag_o  (cc_flags[c]),
      .oc_flag_o  (oc_flags[c])
    );
  end

  always_comb begin
    word = '0;
    word[UPD_POS] = upd_q;
    word[TRG_POS] = trg_q;
    word[CC_BASE +: NCH] = cc_flags;
    word[OC_BASE +: NCH] = oc_flags;
  end

  assign rd_data_o = word;
  assign irq_o     = |(word & irq_en_i);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~USED) == '0);

  // R3
  upd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_evt_i |=> rd_data_o[0]);

  // R8
  trig_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_evt |=> rd_data_o[6]);

  // R10
  partial_strb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_strb_i != 4'hF && rd_data_o[0]) |=> rd_data_o[0]);
endmodule

// File: tb/tfr_status_top_test.sv
module tfr_status_top_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic [3:0]  cap = '0;
  logic [3:0]  cmp = '0;
  logic [3:0]  chan_in = '0;
  logic        trig = 1'b0;
  logic        pol = 1'b0;
  logic [2:0]  mode = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_strb = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] irq_en = '0;
  logic [31:0] rd;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tfr_status_top uut (
    .clk_i(clk), .rst_ni(rst_n), .upd_evt_i(upd), .cap_evt_i(cap),
    .cmp_evt_i(cmp), .chan_in_i(chan_in), .trig_i(trig), .trig_pol_i(pol),
    .slv_mode_i(mode), .wr_en_i(wr_en), .wr_strb_i(wr_strb),
    .wr_data_i(wr_data), .irq_en_i(irq_en), .rd_data_o(rd), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] s);
    wr_en = 1'b1; wr_data = d; wr_strb = s;
    tick();
    wr_en = 1'b0; wr_strb = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rd, 32'h0, "R1 status after reset");
    chk({31'h0, irq}, 32'h0, "R1 irq after reset");

    // R3 and R6
    upd = 1'b1; tick(); upd = 1'b0;
    chk(rd, 32'h1, "R3 update flag");
    wr(32'hFFFF_FFFF, 4'hF);
    chk(rd, 32'h1, "R6 write one keeps flag");
    wr(~32'h1, 4'hF);
    chk(rd, 32'h0, "R6 write zero clears flag");

    // R10: each partial strobe leaves the flag
    upd = 1'b1; tick(); upd = 1'b0;
    for (int b = 0; b < 4; b++) begin
      wr(32'h0, 4'hF & ~(4'h1 << b));
      chk(rd, 32'h1, "R10 partial strobe ignored");
    end
    wr(32'h0, 4'hF);

    // R4 R5 sweep over channels and modes
    for (int ch = 0; ch < 4; ch++) begin
      for (int m = 0; m < 2; m++) begin
        chan_in = (m == 1) ? (4'h1 << ch) : 4'h0;
        wr(32'h0, 4'hF);
        cap[ch] = 1'b1; tick(); cap = '0;
        chk(rd, (m == 1) ? (32'h1 << (1 + ch)) : 32'h0, "R4 capture strobe");
        wr(32'h0, 4'hF);
        cmp[ch] = 1'b1; tick(); cmp = '0;
        chk(rd, (m == 0) ? (32'h1 << (1 + ch)) : 32'h0, "R4 compare strobe");
        wr(32'h0, 4'hF);
        cap[ch] = 1'b1; cmp[ch] = 1'b1; tick(); tick(); cap = '0; cmp = '0;
        chk(rd, (32'h1 << (1 + ch)) | ((m == 1) ? (32'h1 << (9 + ch)) : 32'h0),
            "R5 second event over-capture");
        wr(32'h0, 4'hF);
        chk(rd, 32'h0, "R6 clear all");
      end
    end

    // R7 set beats clear; R5 uses flag from before the edge
    chan_in = 4'hF;
    cap[0] = 1'b1; wr(32'h0, 4'hF); cap = '0;
    chk(rd, 32'h2, "R7 set wins over clear");
    cap[0] = 1'b1; wr(32'h0, 4'hF); cap = '0;
    chk(rd, 32'h202, "R7 R5 collision with set flag");
    wr(32'h0, 4'hF);

    // R8 R9 trigger sweep
    for (int mi = 0; mi < 5; mi++) begin
      for (int p = 0; p < 2; p++) begin
        for (int e = 0; e < 2; e++) begin
          logic [2:0] mv;
          logic exp_t;
          mv = (mi == 0) ? 3'd0 : (mi == 1) ? 3'd1 : (mi == 2) ? 3'd3 :
               (mi == 3) ? 3'd5 : 3'd7;
          mode = mv; pol = p[0];
          trig = ~e[0];
          repeat (5) tick();
          wr(32'h0, 4'hF);
          trig = e[0];
          repeat (2) tick();
          chk(rd & 32'h40, 32'h0, "R8 trigger latency not early");
          tick();
          if (mv == 3'd0)      exp_t = 1'b0;
          else if (mv == 3'd5) exp_t = 1'b1;
          else                 exp_t = (e[0] != p[0]);
          if (mv == 3'd5) chk(rd & 32'h40, {25'h0, exp_t, 6'h0}, "R9 pause edge");
          else            chk(rd & 32'h40, {25'h0, exp_t, 6'h0}, "R8 trigger edge rule");
        end
      end
    end
    mode = 3'd0;
    repeat (4) tick();
    wr(32'h0, 4'hF);

    // R11 enable sweep with flags at bits 0 and 2
    upd = 1'b1; cap[1] = 1'b1; tick(); upd = 1'b0; cap = '0;
    for (int k = 0; k < 32; k++) begin
      irq_en = 32'h1 << k;
      #1;
      chk({31'h0, irq}, {31'h0, (k == 0 || k == 2)}, "R11 irq per enable bit");
    end
    irq_en = '0;
    wr(32'h0, 4'hF);

    // R2 full layout
    chan_in = 4'hF;
    upd = 1'b1; cap = 4'hF; tick(); tick(); upd = 1'b0; cap = '0;
    mode = 3'd5; trig = ~trig;
    repeat (4) tick();
    chk(rd, 32'h0000_1E5F, "R2 full status layout");
    irq_en = 32'hFFFF_FFFF;
    #1;
    chk({31'h0, irq}, 32'h1, "R11 irq all enabled");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule